// File: doc/BRIEF.md
# Signed-Count Word Shifter

This block shifts a 16-bit data word by a signed count, with zeros filling the vacated bits. A non-negative count shifts the word toward the most significant end. A negative count shifts it toward the least significant end by the count's magnitude. Any magnitude larger than 15 saturates the result to zero rather than wrapping the count.

The count comes from one of two places, chosen per request. The first is a full 16-bit word, as taken from the top of an operand stack. The second is an 8-bit immediate that is sign-extended to 16 bits before the same decode. A request is a beat on a valid/ready input channel. The registered result leaves on a valid/ready output channel.

The input is accepted when `in_valid` and `in_ready` are both high at a clock edge. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the result holds and no new request is taken. With `out_ready` held high, the block accepts one request per cycle.

Top module: `signed_word_shifter`

## Requirements
- R1: After reset, `out_valid` is low and `in_ready` is high.
- R2: With a count from 1 to 15, the result is `data_in` shifted toward the MSB by the count, with zeros in the low bits.
- R3: With a non-negative count whose bits above bit 3 are not all zero (count 16 to 32767), the result is zero.
- R4: With a count from -15 to -1, the result is `data_in` shifted toward the LSB by the magnitude, with zeros in the high bits (logical shift).
- R5: With a count below -15, the result is zero.
- R6: With `op_sel` = 1, the count is `imm_in` sign-extended from its bit 7, and `count_in` has no effect. With `op_sel` = 0, the count is `count_in`, read as two's complement.
- R7: A count of zero returns `data_in` unchanged.
- R8: The result and `out_valid` appear at the clock edge that accepts the request. With `out_ready` high and no new request, `out_valid` drops after one cycle.
- R9: While `out_valid` is high and `out_ready` is low, `result` and `out_valid` hold and `in_ready` is low.
- R10: With `op_sel` = 0, `imm_in` has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| op_sel | input | 1 | 0: count from `count_in`; 1: count from `imm_in` |
| data_in | input | 16 | Word to shift |
| count_in | input | 16 | Signed word count |
| imm_in | input | 8 | Signed byte count |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| result | output | 16 | Shifted word |

## Verification
Faults in the count decode show up in the very next result after a request. Typical cases are a wrong direction bit, an off-by-one saturation bound at 15/16 or -15/-16, or a bad sign extension of the byte. The bench sweeps every 16-bit count and every byte count, so any such fault appears within one cycle of the offending count. A fault in the output register or in the handshake shows as `out_valid` failing to drop one cycle after delivery, or as the result changing while `out_ready` is held low.

// File: rtl/shf_pkg.sv
package shf_pkg;
  typedef enum logic {
    OP_STACK = 1'b0,
    OP_IMM   = 1'b1
  } shf_op_e;
endpackage

// File: rtl/shf_count_decode.sv
module shf_count_decode #(
  parameter int W     = 16,
  parameter int IMM_W = 8,
  localparam int SHW  = $clog2(W)
) (
  input  logic             op_imm,
  input  logic [W-1:0]     count_word,
  input  logic [IMM_W-1:0] count_byte,
  output logic             go_right,
  output logic [SHW-1:0]   amount,
  output logic             force_zero
);
  logic [W-1:0] cnt;
  logic [W-1:0] neg_cnt;
  logic [W:0]   bias_sum;
  logic         left_over;
  logic         right_over;

  // pick the count source; the byte is sign-extended to full width
  always_comb begin
    if (op_imm) cnt = {{(W-IMM_W){count_byte[IMM_W-1]}}, count_byte};
    else        cnt = count_word;
  end

  assign go_right = cnt[W-1];
  assign neg_cnt  = ~cnt + 1'b1;

  // left path: any bit above the shift field means out of range
  assign left_over = |cnt[W-1:SHW];

  // right path: count + (W-1) without carry means count < -(W-1)
  assign bias_sum   = {1'b0, cnt} + (W+1)'(W-1);
  assign right_over = ~bias_sum[W];

  assign amount     = go_right ? neg_cnt[SHW-1:0] : cnt[SHW-1:0];
  assign force_zero = go_right ? right_over : left_over;

  // R6: an immediate with its top bit set gives an all-ones upper part
  always_comb begin
    if (op_imm && count_byte[IMM_W-1])
      a_r6_sign_extend: assert (cnt[W-1:IMM_W] == '1);
  end
endmodule

// File: rtl/shf_barrel.sv
module shf_barrel #(
  parameter int W    = 16,
  localparam int SHW = $clog2(W)
) (
  input  logic [W-1:0]   din,
  input  logic [SHW-1:0] amt,
  input  logic           right,
  output logic [W-1:0]   dout
);
  logic [W-1:0] rin;
  logic [W-1:0] stg [0:SHW];

  // right shifts reuse the left network on a bit-reversed word
  for (genvar i = 0; i < W; i++) begin : g_rev_in
    assign rin[i] = right ? din[W-1-i] : din[i];
  end

  assign stg[0] = rin;

  for (genvar k = 0; k < SHW; k++) begin : g_stage
    assign stg[k+1] = amt[k] ? (stg[k] << (1 << k)) : stg[k];
  end

  for (genvar i = 0; i < W; i++) begin : g_rev_out
    assign dout[i] = right ? stg[SHW][W-1-i] : stg[SHW][i];
  end
endmodule

// File: rtl/signed_word_shifter.sv
module signed_word_shifter #(
  parameter int W     = 16,
  parameter int IMM_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             op_sel,
  input  logic [W-1:0]     data_in,
  input  logic [W-1:0]     count_in,
  input  logic [IMM_W-1:0] imm_in,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [W-1:0]     result
);
  import shf_pkg::*;

  localparam int SHW = $clog2(W);

  shf_op_e        op;
  logic           go_right;
  logic [SHW-1:0] amount;
  logic           force_zero;
  logic [W-1:0]   shifted;
  logic           in_fire;
  logic           valid_q;
  logic [W-1:0]   result_q;

  assign op = shf_op_e'(op_sel);

  shf_count_decode #(.W(W), .IMM_W(IMM_W)) i_decode (
    .op_imm     (op == OP_IMM),
    .count_word (count_in),
    .count_byte (imm_in),
    .go_right   (go_right),
    .amount     (amount),
    .force_zero (force_zero)
  );

  shf_barrel #(.W(W)) i_barrel (
    .din   (data_in),
    .amt   (amount),
    .right (go_right),
    .dout  (shifted)
  );

  assign in_ready = ~valid_q | out_ready;
  assign in_fire  = in_valid & in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q  <= 1'b0;
      result_q <= '0;
    end else if (in_fire) begin
      valid_q  <= 1'b1;
      result_q <= force_zero ? '0 : shifted;
    end else if (out_ready) begin
      valid_q  <= 1'b0;
    end
  end

  assign out_valid = valid_q;
  assign result    = result_q;

  // R8: an accepted request is presented on the next cycle
  a_r8_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire |=> out_valid);

  // R8: a drained result with no new request leaves the output empty
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !in_valid) |=> !out_valid);

  // R9: a stalled result holds its value
  a_r9_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(result)));

  // R3 and R5: out-of-range counts saturate to zero
  a_r5_saturate_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fire && force_zero) |=> (result == '0));

  // R7: a zero shift passes the operand through
  a_r7_identity: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fire && !force_zero && amount == '0) |=> (result == $past(data_in)));
endmodule

// File: tb/test_signed_word_shifter.sv
module test_signed_word_shifter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        op_sel = 1'b0;
  logic [15:0] data_in = '0;
  logic [15:0] count_in = '0;
  logic [7:0]  imm_in = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [15:0] result;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  signed_word_shifter i_signed_word_shifter (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .op_sel(op_sel), .data_in(data_in), .count_in(count_in), .imm_in(imm_in),
    .out_valid(out_valid), .out_ready(out_ready), .result(result)
  );

  function automatic logic [15:0] expect_shift(input logic [15:0] d, input int c);
    if (c >= 0) return (c > 15) ? 16'h0 : 16'(d << c);
    return (c < -15) ? 16'h0 : 16'(d >> (-c));
  endfunction

  function automatic string tag_of(input int c);
    if (c == 0)   return "R7";
    if (c > 15)   return "R3";
    if (c > 0)    return "R2";
    if (c < -15)  return "R5";
    return "R4";
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one request, result checked one cycle later with out_ready high
  task automatic run_op(input string tag, input logic imm, input logic [15:0] d,
                        input logic [15:0] cw, input logic [7:0] cb,
                        input logic [15:0] exp);
    @(negedge clk);
    in_valid = 1'b1; op_sel = imm; data_in = d; count_in = cw; imm_in = cb;
    @(negedge clk);
    in_valid = 1'b0;
    check({tag, " valid"}, {15'h0, out_valid}, 16'h1);
    check(tag, result, exp);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 out_valid", {15'h0, out_valid}, 16'h0);
    check("R1 in_ready", {15'h0, in_ready}, 16'h1);
    rst_n = 1'b1;

    // near-boundary sweep with several data patterns, junk immediate (R10)
    for (int p = 0; p < 6; p++) begin
      logic [15:0] d;
      d = (p == 0) ? 16'hFFFF : (p == 1) ? 16'h8001 : (p == 2) ? 16'h0001 :
          (p == 3) ? 16'hA5C3 : (p == 4) ? 16'h8000 : 16'h1234;
      for (int c = -18; c <= 18; c++)
        run_op(tag_of(c), 1'b0, d, 16'(c), 8'(p * 37 + c), expect_shift(d, c));
    end

    // R10: same count, different immediates, same result
    run_op("R10", 1'b0, 16'hC3A5, 16'd3, 8'h00, 16'h1D28);
    run_op("R10", 1'b0, 16'hC3A5, 16'd3, 8'hFB, 16'h1D28);

    // R6: every byte count, junk word count
    for (int b = 0; b < 256; b++) begin
      logic [15:0] d;
      int c;
      d = 16'hB6D9 ^ 16'(b * 16'h0101);
      c = (b > 127) ? b - 256 : b;
      run_op("R6", 1'b1, d, 16'(b * 16'h1357 + 16'h4000), 8'(b), expect_shift(d, c));
    end

    // full sweep of every 16-bit word count
    for (int w = 0; w < 65536; w++) begin
      logic [15:0] d;
      int c;
      d = 16'hA5C3 ^ 16'(w * 16'h9E37);
      c = (w > 32767) ? w - 65536 : w;
      run_op(tag_of(c), 1'b0, d, 16'(w), 8'(w >> 3), expect_shift(d, c));
    end

    // R8: valid lasts one cycle when no new request follows
    run_op("R8", 1'b0, 16'h00F0, 16'hFFFC, 8'h00, 16'h000F);
    @(negedge clk);
    check("R8 pulse end", {15'h0, out_valid}, 16'h0);

    // R9: back-pressure holds result and blocks input
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; op_sel = 1'b0; data_in = 16'h0101; count_in = 16'd4;
    @(negedge clk);
    data_in = 16'hFFFF; count_in = 16'd1;
    for (int s = 0; s < 3; s++) begin
      check("R9 valid held", {15'h0, out_valid}, 16'h1);
      check("R9 result held", result, 16'h1010);
      check("R9 in_ready", {15'h0, in_ready}, 16'h0);
      @(negedge clk);
    end
    in_valid = 1'b0;
    out_ready = 1'b1;
    @(negedge clk);
    check("R9 drained", {15'h0, out_valid}, 16'h0);
    check("R9 no stray accept", result, 16'h1010);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule